// File: doc/BRIEF.md
# Video Memory DMA Engine

This engine fills the display memories without help from the CPU. A start pulse launches one of three operations. A transfer moves 16-bit words from the system bus into the video RAM, the colour memory or the scroll memory. A copy moves bytes from one part of video RAM to another. A fill writes a single constant byte across video RAM.

The source address, the length and the operation all come from five 8-bit configuration registers held in the port block. The engine unpacks them when the start pulse arrives. The port block also supplies the write destination and the destination step. For a transfer, the engine takes over the system bus with a request and acknowledge handshake and keeps it until the last word has landed. When any operation ends, the engine raises a one-cycle done pulse that the port block uses to clear the stored operation. A busy flag stays high for as long as an operation is in progress.

Top module: `vram_dma_engine`

## Requirements
- R1: At start the length is `{cfg_len_hi, cfg_len_lo}`. The source byte address is `{cfg_src_hi[6:0], cfg_src_mid, cfg_src_lo, 1'b0}`. The operation is set by `cfg_src_hi[7:6]`: `0x` selects a transfer (bit 6 becomes source bit 23), `10` selects a fill and `11` selects a copy.
- R2: A transfer raises `bus_req` in the cycle after start. It issues no `rd_req` until `bus_ack` is high, and it drops `bus_req` by the done cycle.
- R3: Each transfer step reads one word at the source. The high byte goes to the destination and the low byte to destination+1, in that order. The source then advances by 2 and the destination by `cfg_step`.
- R4: Each copy step reads the video RAM byte at the source through `vram_re` (data returned one cycle later) and writes it to the destination. The source then advances by 1 and the destination by `cfg_step`.
- R5: A fill writes nothing until a `fill_wr` pulse arrives. It then writes `fill_data[15:8]` at the destination on each step, and the destination advances by `cfg_step`.
- R6: An operation performs exactly `length` steps. A length of zero performs no write and completes at once.
- R7: `busy` rises in the cycle after an accepted start. `done` pulses for one cycle at the end, and `busy` is low in the cycle after `done`.
- R8: `mem_sel` is 0 for video RAM, 1 for colour memory and 2 for scroll memory. Copy and fill always target video RAM. Destination addresses wrap modulo 2^VRAM_AW, 2^CRAM_AW or 2^VSRAM_AW according to the target.
- R9: A start pulse has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse |
| cfg_len_lo | input | 8 | Length, low byte |
| cfg_len_hi | input | 8 | Length, high byte |
| cfg_src_lo | input | 8 | Source word address bits 7:0 |
| cfg_src_mid | input | 8 | Source word address bits 15:8 |
| cfg_src_hi | input | 8 | Operation bits [7:6], source word address bits [6:0] |
| cfg_step | input | 8 | Destination step per write step |
| cfg_dest | input | VRAM_AW | Start destination address |
| cfg_target | input | 2 | Transfer target memory |
| fill_wr | input | 1 | Data-port write strobe |
| fill_data | input | 16 | Data-port write value |
| bus_req | output | 1 | System bus request |
| bus_ack | input | 1 | System bus grant |
| rd_req | output | 1 | System read request, held until rd_valid |
| rd_addr | output | 24 | System read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data word |
| vram_re | output | 1 | Video RAM read enable |
| vram_raddr | output | VRAM_AW | Video RAM read address |
| vram_rdata | input | 8 | Video RAM read byte, one cycle after vram_re |
| mem_we | output | 1 | Target memory byte write |
| mem_sel | output | 2 | Target memory select |
| mem_addr | output | VRAM_AW | Target byte address |
| mem_wdata | output | 8 | Target byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |

## Verification
`busy` follows an accepted start after one clock edge, so the bench samples it at the next falling edge. `busy` drops one edge after `done`, and the bench samples it at the falling edge that follows the `done` sample. The spacing of writes depends on the handshakes: a transfer takes at least four cycles per word, a copy two cycles per byte and a fill one cycle per byte. For this reason the bench does not time individual writes. It logs every write at falling edges and compares the logged sequence with an arithmetic model once `done` is seen. Silence before the fill data and before the bus grant is checked by sampling the write and read strobes on every falling edge of those waiting windows.

// File: rtl/vdma_pkg.sv
// Shared types for the video memory DMA engine.
// Assumes: the operation field is two bits and the target select is two bits.
package vdma_pkg;

    typedef enum logic [1:0] {
        OP_XFER = 2'd0,
        OP_FILL = 2'd2,
        OP_COPY = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2
    } tgt_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILLWAIT,
        S_BUSREQ,
        S_READ,
        S_WRHI,
        S_WRLO,
        S_CPRD,
        S_CPWR,
        S_FILL,
        S_DONE
    } state_t;

    // Map the two operation bits; a clear top bit always means transfer.
    function automatic op_t decode_op(input logic [1:0] bits);
        if (!bits[1]) return OP_XFER;
        return bits[0] ? OP_COPY : OP_FILL;
    endfunction

endpackage

// File: rtl/vdma_counter.sv
// Remaining-step counter.
// Assumes: load and dec never coincide; dec is only raised while the count is nonzero.
module vdma_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    // Hold the number of steps still to perform.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= len;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    // The current step is the final one.
    always_comb last = (cnt_q == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/vdma_addr_gen.sv
// Source and destination address registers with per-target wrap.
// Assumes: CRAM_AW and VSRAM_AW do not exceed VRAM_AW, and VRAM_AW exceeds 8.
module vdma_addr_gen
    import vdma_pkg::*;
#(
    parameter int VRAM_AW  = 16,
    parameter int CRAM_AW  = 7,
    parameter int VSRAM_AW = 7,
    parameter int SRC_W    = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SRC_W-1:0]   src_init,
    input  logic [VRAM_AW-1:0] dest_init,
    input  logic [7:0]         step_init,
    input  tgt_t               tgt_init,
    input  logic               step,
    input  logic               src_by2,
    output logic [SRC_W-1:0]   src,
    output logic [VRAM_AW-1:0] dest,
    output logic [VRAM_AW-1:0] dest_p1,
    output tgt_t               tgt
);
    localparam int PAD = VRAM_AW - 8;

    logic [VRAM_AW-1:0] step_q;

    // Keep an address within the selected memory.
    function automatic logic [VRAM_AW-1:0] wrap(input logic [VRAM_AW-1:0] a, input tgt_t t);
        logic [VRAM_AW-1:0] m;
        case (t)
            TGT_CRAM:  m = VRAM_AW'((1 << CRAM_AW) - 1);
            TGT_VSRAM: m = VRAM_AW'((1 << VSRAM_AW) - 1);
            default:   m = '1;
        endcase
        return a & m;
    endfunction

    // Load the start state, then advance both addresses on each write step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src    <= '0;
            dest   <= '0;
            step_q <= '0;
            tgt    <= TGT_VRAM;
        end else if (load) begin
            src    <= src_init;
            dest   <= wrap(dest_init, tgt_init);
            step_q <= {{PAD{1'b0}}, step_init};
            tgt    <= tgt_init;
        end else if (step) begin
            src  <= src + (src_by2 ? SRC_W'(2) : SRC_W'(1));
            dest <= wrap(dest + step_q, tgt);
        end
    end

    // Address of the second byte of a word.
    always_comb dest_p1 = wrap(dest + 1'b1, tgt);
endmodule

// File: rtl/vdma_fsm.sv
// Sequencer for transfer, copy and fill operations.
// Assumes: rd_valid arrives only while a read is pending; fill_wr is a one-cycle strobe.
module vdma_fsm
    import vdma_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  op_t    op_in,
    input  logic   len_zero,
    input  logic   last,
    input  logic   bus_ack,
    input  logic   rd_valid,
    input  logic   fill_wr,
    output state_t st,
    output op_t    op
);
    state_t nxt;

    // Choose the next state.
    always_comb begin
        nxt = st;
        case (st)
            S_IDLE: if (start) begin
                if (len_zero)            nxt = S_DONE;
                else if (op_in == OP_XFER) nxt = S_BUSREQ;
                else if (op_in == OP_FILL) nxt = S_FILLWAIT;
                else                     nxt = S_CPRD;
            end
            S_FILLWAIT: if (fill_wr)  nxt = S_FILL;
            S_BUSREQ:   if (bus_ack)  nxt = S_READ;
            S_READ:     if (rd_valid) nxt = S_WRHI;
            S_WRHI:     nxt = S_WRLO;
            S_WRLO:     nxt = last ? S_DONE : S_READ;
            S_CPRD:     nxt = S_CPWR;
            S_CPWR:     nxt = last ? S_DONE : S_CPRD;
            S_FILL:     nxt = last ? S_DONE : S_FILL;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // Register the state and capture the operation on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            op <= OP_XFER;
        end else begin
            st <= nxt;
            if (st == S_IDLE && start) op <= op_in;
        end
    end
endmodule

// File: rtl/vram_dma_engine.sv
// Top of the video memory DMA engine: unpacks the configuration, sequences
// the operation and drives the bus, read and byte-write ports.
// Assumes: configuration inputs are stable in the start cycle.
module vram_dma_engine
    import vdma_pkg::*;
#(
    parameter int VRAM_AW  = 16,
    parameter int CRAM_AW  = 7,
    parameter int VSRAM_AW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         cfg_len_lo,
    input  logic [7:0]         cfg_len_hi,
    input  logic [7:0]         cfg_src_lo,
    input  logic [7:0]         cfg_src_mid,
    input  logic [7:0]         cfg_src_hi,
    input  logic [7:0]         cfg_step,
    input  logic [VRAM_AW-1:0] cfg_dest,
    input  logic [1:0]         cfg_target,
    input  logic               fill_wr,
    input  logic [15:0]        fill_data,
    output logic               bus_req,
    input  logic               bus_ack,
    output logic               rd_req,
    output logic [23:0]        rd_addr,
    input  logic               rd_valid,
    input  logic [15:0]        rd_data,
    output logic               vram_re,
    output logic [VRAM_AW-1:0] vram_raddr,
    input  logic [7:0]         vram_rdata,
    output logic               mem_we,
    output logic [1:0]         mem_sel,
    output logic [VRAM_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               busy,
    output logic               done
);
    localparam int LEN_W = 16;
    localparam int SRC_W = 24;

    state_t             st;
    op_t                op, op_in;
    logic [LEN_W-1:0]   len;
    logic [SRC_W-1:0]   src_init, src;
    logic [VRAM_AW-1:0] dest, dest_p1;
    tgt_t               tgt, tgt_in;
    logic               accept, step, last;
    logic [15:0]        word_q;
    logic [7:0]         fill_q;

    // Unpack the configuration registers.
    always_comb begin
        op_in    = decode_op(cfg_src_hi[7:6]);
        len      = {cfg_len_hi, cfg_len_lo};
        src_init = {cfg_src_hi[6:0], cfg_src_mid, cfg_src_lo, 1'b0};
        tgt_in   = (op_in == OP_XFER) ? tgt_t'(cfg_target) : TGT_VRAM;
        accept   = start && (st == S_IDLE);
        step     = (st == S_WRLO) || (st == S_CPWR) || (st == S_FILL);
    end

    vdma_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_in    (op_in),
        .len_zero (len == '0),
        .last     (last),
        .bus_ack  (bus_ack),
        .rd_valid (rd_valid),
        .fill_wr  (fill_wr),
        .st       (st),
        .op       (op)
    );

    vdma_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .len   (len),
        .dec   (step),
        .last  (last)
    );

    vdma_addr_gen #(
        .VRAM_AW  (VRAM_AW),
        .CRAM_AW  (CRAM_AW),
        .VSRAM_AW (VSRAM_AW),
        .SRC_W    (SRC_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .src_init  (src_init),
        .dest_init (cfg_dest),
        .step_init (cfg_step),
        .tgt_init  (tgt_in),
        .step      (step),
        .src_by2   (op == OP_XFER),
        .src       (src),
        .dest      (dest),
        .dest_p1   (dest_p1),
        .tgt       (tgt)
    );

    // Capture the fetched word and the fill byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            fill_q <= '0;
        end else begin
            if (st == S_READ && rd_valid)     word_q <= rd_data;
            if (st == S_FILLWAIT && fill_wr)  fill_q <= fill_data[15:8];
        end
    end

    // Drive the bus, read and write ports from the state.
    always_comb begin
        bus_req    = (st == S_BUSREQ) || (st == S_READ) || (st == S_WRHI) || (st == S_WRLO);
        rd_req     = (st == S_READ);
        rd_addr    = src;
        vram_re    = (st == S_CPRD);
        vram_raddr = src[VRAM_AW-1:0];
        mem_we     = (st == S_WRHI) || (st == S_WRLO) || (st == S_CPWR) || (st == S_FILL);
        mem_sel    = tgt;
        mem_addr   = (st == S_WRLO) ? dest_p1 : dest;
        case (st)
            S_WRHI:  mem_wdata = word_q[15:8];
            S_WRLO:  mem_wdata = word_q[7:0];
            S_CPWR:  mem_wdata = vram_rdata;
            default: mem_wdata = fill_q;
        endcase
        busy = (st != S_IDLE);
        done = (st == S_DONE);
    end
endmodule

// File: rtl/vdma_checker.sv
// Protocol checks for the video memory DMA engine, bound to the top module.
module vdma_checker #(
    parameter int VRAM_AW  = 16,
    parameter int CRAM_AW  = 7,
    parameter int VSRAM_AW = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               bus_req,
    input logic               bus_ack,
    input logic               rd_req,
    input logic               vram_re,
    input logic               mem_we,
    input logic [1:0]         mem_sel,
    input logic [VRAM_AW-1:0] mem_addr,
    input logic               busy,
    input logic               done
);
    localparam int CRAM_SZ  = 1 << CRAM_AW;
    localparam int VSRAM_SZ = 1 << VSRAM_AW;

    assert_rd_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (bus_req && bus_ack));

    assert_bus_free_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_copy_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vram_re |=> (mem_we && mem_sel == 2'd0));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_req || rd_req || mem_we || vram_re));

    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_cram_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_sel == 2'd1) |-> (int'(mem_addr) < CRAM_SZ));

    assert_vsram_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_sel == 2'd2) |-> (int'(mem_addr) < VSRAM_SZ));
endmodule

bind vram_dma_engine vdma_checker #(
    .VRAM_AW  (VRAM_AW),
    .CRAM_AW  (CRAM_AW),
    .VSRAM_AW (VSRAM_AW)
) u_vdma_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .rd_req   (rd_req),
    .vram_re  (vram_re),
    .mem_we   (mem_we),
    .mem_sel  (mem_sel),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_vram_dma_engine.sv
// Sweeping bench: models the system bus and video RAM, logs writes, compares with arithmetic.
module tb_vram_dma_engine;
    localparam int VRAM_AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cfg_len_lo = '0, cfg_len_hi = '0, cfg_src_lo = '0, cfg_src_mid = '0, cfg_src_hi = '0, cfg_step = '0;
    logic [VRAM_AW-1:0] cfg_dest = '0;
    logic [1:0] cfg_target = '0;
    logic fill_wr = 1'b0;
    logic [15:0] fill_data = '0;
    logic bus_req, bus_ack = 1'b0, rd_req, rd_valid = 1'b0, vram_re, mem_we, busy, done;
    logic [23:0] rd_addr;
    logic [15:0] rd_data = '0;
    logic [VRAM_AW-1:0] vram_raddr, mem_addr;
    logic [7:0] vram_rdata = '0, mem_wdata;
    logic [1:0] mem_sel;

    int checks = 0, errors = 0, cycles = 0, early_rd = 0, ack_cnt = 0;
    logic [25:0] act_q[$];
    logic [25:0] exp_q[$];

    vram_dma_engine dut (.*);

    always #10 clk = ~clk;

    function automatic logic [15:0] sysw(input logic [23:0] a);
        return {a[8:1] ^ 8'h3C, a[16:9] ^ a[23:16]};
    endfunction

    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // System bus and video RAM models.
    always @(posedge clk) begin
        rd_valid   <= rd_req && !rd_valid;
        rd_data    <= sysw(rd_addr);
        vram_rdata <= vbyte(vram_raddr);
    end

    // Grant after three cycles of request; log writes; count reads before grant.
    always @(negedge clk) begin
        cycles++;
        if (bus_req) begin ack_cnt++; bus_ack = (ack_cnt >= 3); end
        else begin ack_cnt = 0; bus_ack = 1'b0; end
        if (rd_req && !bus_ack) early_rd++;
        if (mem_we) act_q.push_back({mem_sel, mem_addr, mem_wdata});
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one operation and compare the logged writes with the model.
    task automatic run_op(input logic [1:0] mb, input logic [1:0] tgt, input logic [15:0] len,
                          input logic [23:0] src, input logic [15:0] dst, input logic [7:0] inc,
                          input logic [7:0] fb, input bit restart);
        logic [23:0] s = src;
        logic [15:0] d, m;
        bit xfer = !mb[1];
        int guard = 0;
        m = (!xfer || tgt == 2'd0) ? 16'hFFFF : 16'h007F;
        d = dst & m;
        exp_q.delete();
        for (int k = 0; k < len; k++) begin
            if (xfer) begin
                exp_q.push_back({tgt, d, sysw(s)[15:8]});
                exp_q.push_back({tgt, 16'((d + 1) & m), sysw(s)[7:0]});
                s = s + 24'd2;
            end else if (mb[0]) begin
                exp_q.push_back({2'd0, d, vbyte(s[15:0])});
                s = s + 24'd1;
            end else begin
                exp_q.push_back({2'd0, d, fb});
            end
            d = 16'((d + inc) & m);
        end
        @(negedge clk);
        act_q.delete();
        early_rd = 0;
        cfg_len_lo = len[7:0]; cfg_len_hi = len[15:8];
        cfg_src_lo = src[8:1]; cfg_src_mid = src[16:9];
        cfg_src_hi = xfer ? {1'b0, src[23:17]} : {mb, src[22:17]};
        cfg_step = inc; cfg_dest = dst; cfg_target = tgt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", 32'(busy), 32'd1);
        if (restart) begin
            @(negedge clk);
            cfg_src_hi = 8'h80; cfg_len_lo = 8'd9; cfg_dest = 16'h0100;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (mb == 2'b10 && len != 0) begin
            repeat (5) @(negedge clk);
            chk(act_q.size() == 0, "R5 no write before data", 32'(act_q.size()), 32'd0);
            fill_data = {fb, 8'h77};
            fill_wr = 1'b1;
            @(negedge clk);
            fill_wr = 1'b0;
        end
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk(done == 1'b1, "R7 done pulse", 32'(done), 32'd1);
        if (xfer) chk(bus_req == 1'b0, "R2 bus released at done", 32'(bus_req), 32'd0);
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy cleared", 32'(busy), 32'd0);
        if (xfer && len != 0) chk(early_rd == 0, "R2 read before grant", 32'(early_rd), 32'd0);
        chk(act_q.size() == exp_q.size(), restart ? "R9 restart ignored count" : "R6 step count",
            32'(act_q.size()), 32'(exp_q.size()));
        for (int k = 0; k < exp_q.size() && k < act_q.size(); k++)
            chk(act_q[k] == exp_q[k],
                restart ? "R9 restart ignored data" :
                xfer ? "R3 R8 transfer write" : (mb[0] ? "R4 copy write" : "R5 fill write"),
                32'(act_q[k]), 32'(exp_q[k]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !mem_we && !rd_req && !done, "R7 reset state",
            {27'd0, busy, bus_req, mem_we, rd_req, done}, 32'd0);
        // R1 R3 R8: transfer sweep over targets, lengths and steps, bit 23 set in the source.
        for (int t = 0; t < 3; t++)
            for (int n = 0; n < 4; n++)
                for (int i = 1; i <= 3; i++)
                    run_op(2'b00, 2'(t), 16'(n), 24'h812340 + 24'(t * 6),
                           (t == 0) ? 16'hFFFA : 16'h007C, 8'(i), 8'h00, 1'b0);
        // R4: copy sweep crossing the top of video RAM.
        for (int n = 1; n <= 4; n++)
            for (int i = 1; i <= 2; i++)
                run_op(2'b11, 2'd1, 16'(n), 24'h001FFE, 16'hFFFE, 8'(i), 8'h00, 1'b0);
        // R5 R6: fill sweep including zero length.
        for (int n = 0; n < 4; n++)
            for (int i = 1; i <= 3; i += 2)
                run_op(2'b10, 2'd2, 16'(n), 24'h0, 16'hFFFD, 8'(i), 8'hC6 + 8'(n), 1'b0);
        // R1 R6: length using the high byte.
        run_op(2'b10, 2'd0, 16'h0102, 24'h0, 16'h4000, 8'd1, 8'h3B, 1'b0);
        // R9: second start during a copy.
        run_op(2'b11, 2'd0, 16'd5, 24'h000200, 16'h2000, 8'd2, 8'h00, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule